// File: doc/BRIEF.md
# Card Command-Line Response Receiver

This block listens on the bidirectional command line of a memory card while the host has stopped driving it. The controller arms it with a one-cycle `start` pulse and says whether a 48-bit short reply or a 136-bit identification reply is expected. The receiver then watches the line on each card-clock rising edge. The host marks these edges with a single-cycle `card_tick` strobe in the system clock domain. The receiver aligns to the first low sample it sees, which is the start bit, and shifts in the rest of the reply. When the reply is complete it presents the whole frame.

From the frame it extracts three fields. The first is the 32-bit argument word of a short reply. The second is the power-up-complete flag of the operating-condition reply. The third is the 16-bit card address carried by the address-assignment reply. If the card stays silent for a programmable number of clocks, the receiver raises a timeout and returns to idle. After a good reply it also counts the eight trailing clocks that must be issued before the next command. Its `next_ok` output tells the sequencer when the line may be reused.

Top module: `sdrx_cmd_rsp_rx`

## Requirements
- R1: After reset, `next_ok` is 1, `rsp_valid` and `rsp_timeout` are 0, and `rsp_frame`, `rsp_payload`, `rsp_ready` and `rsp_rca` are all zero.
- R2: `start` is accepted only while `next_ok` is 1. An accepted start clears the frame, the fields and the timeout flag on the following clock edge and drops `next_ok`.
- R3: The line is sampled only in cycles where `card_tick` is 1 and `host_drive` is 0. Any other cycle neither detects a start bit, nor advances the silence count, nor shifts a bit.
- R4: While waiting, a sampled 1 is idle. The first sampled 0 is the start bit and becomes frame bit 47 (short) or bit 135 (long). Later bits fill the frame downward, most significant bit first.
- R5: With `long_sel` at 0 when started, the 48th counted sample produces a one-cycle `rsp_valid` pulse on the edge that samples it. The reply sits in `rsp_frame[47:0]` and the upper bits read 0.
- R6: With `long_sel` at 1 when started, the capture ends after 136 counted samples, and all 136 bits appear in `rsp_frame`.
- R7: `rsp_payload` equals `rsp_frame[39:8]`. `rsp_ready` equals payload bit 31, where 0 means the card is still busy. `rsp_rca` equals payload bits 31 down to 16.
- R8: After 64 (`SILENCE_LIMIT`) consecutive counted samples of 1 with no start bit, `rsp_timeout` rises, and `next_ok` rises on the same edge. A start bit on the 64th sample is still captured normally.
- R9: After `rsp_valid`, `next_ok` stays 0 for 7 counted card ticks and rises on the 8th (`TRAIL_TICKS`). During this trailing count, ticks are counted whatever `host_drive` is.
- R10: The frame, the fields and `rsp_timeout` hold their values until the next accepted start. `rsp_valid` and `rsp_timeout` are never 1 together.
- R11: A `start` pulse during a capture or during the trailing count has no effect on the reply being received, or on when `next_ok` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| card_tick | input | 1 | One-cycle strobe marking a card-clock rising edge |
| host_drive | input | 1 | 1 while the host drives the command line; sampling is suppressed |
| cmd_line | input | 1 | Value read back from the command line |
| start | input | 1 | Arms a capture (taken only when `next_ok` is 1) |
| long_sel | input | 1 | 0: 48-bit reply expected, 1: 136-bit reply expected |
| next_ok | output | 1 | Receiver idle and trailing clocks done |
| rsp_valid | output | 1 | One-cycle pulse when a reply has been captured |
| rsp_timeout | output | 1 | No start bit within the silence limit; held until next start |
| rsp_frame | output | LONG_LEN (136) | Captured reply, right-aligned |
| rsp_payload | output | 32 | Argument word, frame bits 39..8 |
| rsp_ready | output | 1 | Payload bit 31, the power-up-complete flag |
| rsp_rca | output | 16 | Payload bits 31..16, the card address |

## Verification
The main capture path is driven with several reply types, and each one separates a different set of faults. Short replies with the ready flag clear and set show whether the field slicing and the ready bit are decoded correctly. A long reply with distinct nibbles shows whether the bit order is right and whether the length selection works. A reply preceded by many low samples taken while the host still drives the line shows whether the host-drive gating suppresses sampling. A reply that starts on exactly the 64th silent sample, set against a run of 64 high samples, pins the timeout boundary. Stray start pulses during a reply and during the trailing count confirm that arming is ignored while the receiver is busy.

// File: rtl/sdrx_pkg.sv
package sdrx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_WAIT  = 2'd1,
        RX_SHIFT = 2'd2,
        RX_TRAIL = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic [31:0] payload;
        logic        ready;
        logic [15:0] rca;
    } rsp_fields_t;

    localparam int unsigned SHORT_BITS = 48;

    // Field slicing for a short reply frame (bit 47 is the start bit).
    function automatic rsp_fields_t slice_fields(input logic [SHORT_BITS-1:0] f);
        rsp_fields_t r;
        r.payload = f[39:8];
        r.ready   = f[39];
        r.rca     = f[39:24];
        return r;
    endfunction

endpackage

// File: rtl/sdrx_seq.sv
module sdrx_seq
    import sdrx_pkg::*;
#(
    parameter int unsigned SHORT_LEN     = 48,
    parameter int unsigned LONG_LEN      = 136,
    parameter int unsigned SILENCE_LIMIT = 64,
    parameter int unsigned TRAIL_TICKS   = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic card_tick,
    input  logic host_drive,
    input  logic cmd_line,
    input  logic start,
    input  logic long_sel,
    output logic idle,
    output logic clear,
    output logic shift_en,
    output logic done,
    output logic timed_out
);
    localparam int unsigned MAXV = (LONG_LEN > SILENCE_LIMIT) ? LONG_LEN : SILENCE_LIMIT;
    localparam int unsigned CW   = $clog2(MAXV + TRAIL_TICKS + 1);
    localparam logic [CW-1:0] SHORT_REM = CW'(SHORT_LEN - 1);
    localparam logic [CW-1:0] LONG_REM  = CW'(LONG_LEN - 1);
    localparam logic [CW-1:0] SIL_LAST  = CW'(SILENCE_LIMIT - 1);
    localparam logic [CW-1:0] TRL_LAST  = CW'(TRAIL_TICKS - 1);
    localparam logic [CW-1:0] ONE       = CW'(1);

    rx_state_e     st;
    logic [CW-1:0] cnt;
    logic          long_q;
    logic          smp;

    assign smp      = card_tick && !host_drive;
    assign idle     = (st == RX_IDLE);
    assign clear    = idle && start;
    assign shift_en = smp && ((st == RX_WAIT && !cmd_line) || st == RX_SHIFT);
    assign done     = smp && (st == RX_SHIFT) && (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= RX_IDLE;
            cnt       <= '0;
            long_q    <= 1'b0;
            timed_out <= 1'b0;
        end else begin
            case (st)
                RX_IDLE: begin
                    if (start) begin
                        st        <= RX_WAIT;
                        cnt       <= '0;
                        long_q    <= long_sel;
                        timed_out <= 1'b0;
                    end
                end
                RX_WAIT: begin
                    if (smp) begin
                        if (!cmd_line) begin
                            st  <= RX_SHIFT;
                            cnt <= long_q ? LONG_REM : SHORT_REM;
                        end else if (cnt == SIL_LAST) begin
                            st        <= RX_IDLE;
                            cnt       <= '0;
                            timed_out <= 1'b1;
                        end else begin
                            cnt <= cnt + ONE;
                        end
                    end
                end
                RX_SHIFT: begin
                    if (smp) begin
                        if (cnt == ONE) begin
                            st  <= RX_TRAIL;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt - ONE;
                        end
                    end
                end
                default: begin
                    if (card_tick) begin
                        if (cnt == TRL_LAST) begin
                            st  <= RX_IDLE;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + ONE;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/sdrx_shreg.sv
module sdrx_shreg #(
    parameter int unsigned W = 135
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] held
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            held <= '0;
        end else if (shift_en) begin
            held <= {held[W-2:0], bit_in};
        end
    end
endmodule

// File: rtl/sdrx_capture.sv
module sdrx_capture
    import sdrx_pkg::*;
#(
    parameter int unsigned LONG_LEN = 136
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                done,
    input  logic [LONG_LEN-1:0] next_frame,
    output logic [LONG_LEN-1:0] frame,
    output rsp_fields_t         fields,
    output logic                valid
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            frame  <= '0;
            fields <= '0;
            valid  <= 1'b0;
        end else if (done) begin
            frame  <= next_frame;
            fields <= slice_fields(next_frame[SHORT_BITS-1:0]);
            valid  <= 1'b1;
        end else begin
            valid  <= 1'b0;
        end
    end
endmodule

// File: rtl/sdrx_cmd_rsp_rx.sv
module sdrx_cmd_rsp_rx
    import sdrx_pkg::*;
#(
    parameter int unsigned SHORT_LEN     = 48,
    parameter int unsigned LONG_LEN      = 136,
    parameter int unsigned SILENCE_LIMIT = 64,
    parameter int unsigned TRAIL_TICKS   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                card_tick,
    input  logic                host_drive,
    input  logic                cmd_line,
    input  logic                start,
    input  logic                long_sel,
    output logic                next_ok,
    output logic                rsp_valid,
    output logic                rsp_timeout,
    output logic [LONG_LEN-1:0] rsp_frame,
    output logic [31:0]         rsp_payload,
    output logic                rsp_ready,
    output logic [15:0]         rsp_rca
);
    localparam int unsigned HW = LONG_LEN - 1;

    logic        clear, shift_en, done;
    logic [HW-1:0] held;
    rsp_fields_t fields;

    sdrx_seq #(
        .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN),
        .SILENCE_LIMIT(SILENCE_LIMIT), .TRAIL_TICKS(TRAIL_TICKS)
    ) u_seq (
        .clk(clk), .rst(rst), .card_tick(card_tick), .host_drive(host_drive),
        .cmd_line(cmd_line), .start(start), .long_sel(long_sel),
        .idle(next_ok), .clear(clear), .shift_en(shift_en), .done(done),
        .timed_out(rsp_timeout)
    );

    sdrx_shreg #(.W(HW)) u_shreg (
        .clk(clk), .rst(rst), .clear(clear), .shift_en(shift_en),
        .bit_in(cmd_line), .held(held)
    );

    sdrx_capture #(.LONG_LEN(LONG_LEN)) u_cap (
        .clk(clk), .rst(rst), .clear(clear), .done(done),
        .next_frame({held, cmd_line}), .frame(rsp_frame),
        .fields(fields), .valid(rsp_valid)
    );

    assign rsp_payload = fields.payload;
    assign rsp_ready   = fields.ready;
    assign rsp_rca     = fields.rca;
endmodule

// File: rtl/sdrx_cmd_rsp_rx_chk.sv
module sdrx_cmd_rsp_rx_chk #(
    parameter int unsigned LONG_LEN = 136
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                next_ok,
    input logic                rsp_valid,
    input logic                rsp_timeout,
    input logic [LONG_LEN-1:0] rsp_frame
);
    // R5: completion is a single-cycle pulse
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R10: never complete and time out together
    p_no_valid_timeout_r10: assert property (@(posedge clk) disable iff (rst)
        !(rsp_valid && rsp_timeout));

    // R8: a timeout returns the receiver to idle
    p_timeout_idle_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_timeout) |-> next_ok);

    // R9: completion is followed by the trailing count, not idle
    p_valid_trail_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !next_ok);

    // R2: leaving idle needs an accepted start
    p_leave_idle_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(next_ok) |-> $past(start));

    // R10: frame held except on completion or after a start
    p_frame_held_r10: assert property (@(posedge clk) disable iff (rst)
        (!rsp_valid && !$past(start)) |-> $stable(rsp_frame));
endmodule

bind sdrx_cmd_rsp_rx sdrx_cmd_rsp_rx_chk #(.LONG_LEN(LONG_LEN)) u_chk (
    .clk(clk), .rst(rst), .start(start), .next_ok(next_ok),
    .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .rsp_frame(rsp_frame)
);

// File: tb/sdrx_cmd_rsp_rx_bench.sv
`timescale 1ns/1ps
module sdrx_cmd_rsp_rx_bench;
    localparam int LL = 136;

    logic clk = 1'b0;
    logic rst, card_tick, host_drive, cmd_line, start, long_sel;
    logic next_ok, rsp_valid, rsp_timeout, rsp_ready;
    logic [LL-1:0] rsp_frame;
    logic [31:0] rsp_payload;
    logic [15:0] rsp_rca;

    always #4 clk = ~clk;

    sdrx_cmd_rsp_rx u_sdrx_cmd_rsp_rx (
        .clk(clk), .rst(rst), .card_tick(card_tick), .host_drive(host_drive),
        .cmd_line(cmd_line), .start(start), .long_sel(long_sel),
        .next_ok(next_ok), .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout),
        .rsp_frame(rsp_frame), .rsp_payload(rsp_payload),
        .rsp_ready(rsp_ready), .rsp_rca(rsp_rca)
    );

    int n_chk = 0;
    int n_bad = 0;
    int n_valid = 0;
    logic [LL-1:0] exp_q[$];

    task automatic chk(input bit ok, input string tag,
                       input logic [LL-1:0] act, input logic [LL-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each completion (R4 R5 R6 R7)
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rsp_valid) begin
                logic [LL-1:0] e;
                n_valid++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected completion", rsp_frame, '0);
                end else begin
                    e = exp_q.pop_front();
                    chk(rsp_frame === e, "R4 frame", rsp_frame, e);
                    chk(rsp_payload === e[39:8], "R7 payload", LL'(rsp_payload), LL'(e[39:8]));
                    chk(rsp_ready === e[39], "R7 ready", LL'(rsp_ready), LL'(e[39]));
                    chk(rsp_rca === e[39:24], "R7 rca", LL'(rsp_rca), LL'(e[39:24]));
                end
            end
        end
    end

    task automatic tick_bit(input logic b, input logic hd);
        @(negedge clk);
        cmd_line = b; host_drive = hd; card_tick = 1'b1;
        @(negedge clk);
        card_tick = 1'b0; host_drive = 1'b0; cmd_line = 1'b1;
    endtask

    task automatic pulse_start(input logic l);
        @(negedge clk);
        start = 1'b1; long_sel = l;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Driver: pushes the expected frame then drives it MSB first
    task automatic send_frame(input logic is_long, input logic [LL-1:0] f, input int stray_at);
        int n = is_long ? 136 : 48;
        exp_q.push_back(is_long ? f : {88'b0, f[47:0]});
        for (int i = n - 1; i >= 0; i--) begin
            if (i == stray_at) start = 1'b1;
            tick_bit(f[i], 1'b0);
            start = 1'b0;
        end
    endtask

    task automatic trail();
        for (int i = 0; i < 8; i++) tick_bit(1'b1, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [LL-1:0] fb;
        int v0;
        rst = 1'b1; card_tick = 1'b0; host_drive = 1'b0; cmd_line = 1'b1;
        start = 1'b0; long_sel = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(next_ok === 1'b1, "R1 next_ok", LL'(next_ok), LL'(1));
        chk(rsp_valid === 1'b0 && rsp_timeout === 1'b0, "R1 flags",
            LL'({rsp_valid, rsp_timeout}), '0);
        chk(rsp_frame === '0 && rsp_payload === '0 && rsp_rca === '0 && rsp_ready === 1'b0,
            "R1 outputs", rsp_frame, '0);

        // Busy reply after some idle highs (R4 R5 R7)
        pulse_start(1'b0);
        chk(next_ok === 1'b0, "R2 next_ok drops", LL'(next_ok), LL'(0));
        repeat (5) tick_bit(1'b1, 1'b0);
        send_frame(1'b0, LL'(48'h3F00FF8000FF), -1);
        chk(next_ok === 1'b0, "R9 low at completion", LL'(next_ok), LL'(0));
        // R11 stray start during trailing count
        pulse_start(1'b1);
        for (int i = 0; i < 7; i++) tick_bit(1'b1, 1'b1);
        chk(next_ok === 1'b0, "R9 low after 7 ticks", LL'(next_ok), LL'(0));
        tick_bit(1'b1, 1'b0);
        chk(next_ok === 1'b1, "R9 high after 8th tick", LL'(next_ok), LL'(1));
        repeat (3) @(negedge clk);
        chk(next_ok === 1'b1, "R11 stray start ignored", LL'(next_ok), LL'(1));

        // Ready reply, then hold and clear (R7 R10 R2)
        pulse_start(1'b0);
        fb = LL'(48'h038ABC12345B);
        send_frame(1'b0, fb, -1);
        trail();
        repeat (10) @(negedge clk);
        chk(rsp_frame === fb, "R10 frame held", rsp_frame, fb);
        chk(rsp_ready === 1'b1 && rsp_rca === 16'h8ABC, "R10 fields held",
            LL'({rsp_ready, rsp_rca}), LL'({1'b1, 16'h8ABC}));
        pulse_start(1'b1);
        chk(rsp_frame === '0 && rsp_payload === '0, "R2 clear on start", rsp_frame, '0);

        // Long reply (R6)
        send_frame(1'b1, 136'h3F0123456789ABCDEFFEDCBA98765432A1, -1);
        trail();

        // Host driving: low samples ignored (R3)
        pulse_start(1'b0);
        v0 = n_valid;
        for (int i = 0; i < 100; i++) tick_bit(1'b0, 1'b1);
        chk(next_ok === 1'b0 && rsp_timeout === 1'b0, "R3 no start no timeout",
            LL'({next_ok, rsp_timeout}), '0);
        chk(n_valid == v0, "R3 no completion", LL'(n_valid), LL'(v0));
        send_frame(1'b0, LL'(48'h2AC001000077), -1);
        trail();

        // Stray start mid-capture (R11)
        pulse_start(1'b0);
        send_frame(1'b0, LL'(48'h071234ABCDA5), 20);
        trail();

        // Timeout boundary (R8 R10 R2)
        pulse_start(1'b0);
        for (int i = 0; i < 63; i++) tick_bit(1'b1, 1'b0);
        chk(rsp_timeout === 1'b0 && next_ok === 1'b0, "R8 no timeout at 63",
            LL'({rsp_timeout, next_ok}), '0);
        tick_bit(1'b1, 1'b0);
        chk(rsp_timeout === 1'b1 && next_ok === 1'b1, "R8 timeout at 64",
            LL'({rsp_timeout, next_ok}), LL'(2'b11));
        repeat (5) @(negedge clk);
        chk(rsp_timeout === 1'b1, "R10 timeout held", LL'(rsp_timeout), LL'(1));
        pulse_start(1'b0);
        chk(rsp_timeout === 1'b0, "R2 timeout cleared", LL'(rsp_timeout), LL'(0));
        for (int i = 0; i < 63; i++) tick_bit(1'b1, 1'b0);
        send_frame(1'b0, LL'(48'h2980FF000001), -1);
        chk(rsp_timeout === 1'b0, "R8 start on 64th sample", LL'(rsp_timeout), LL'(0));
        trail();

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all replies seen", LL'(exp_q.size()), '0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule